// File: doc/BRIEF.md
# Per-Line Sprite Attribute Scanner

This block builds the sprite list for one display line. A pulse on `line_start`, with the line number beside it, begins a scan of a 64-entry attribute table. Each entry is four 16-bit words. The scan visits entries in index order, tests whether each sprite covers the line, and fetches four bitplane words from video memory for every sprite that does. Each hit is written into a list of at most 16 slots.

The list holds, for each slot, the X position, the palette, the raw flag word, the four plane words and a marker that the slot came from table entry 0. A later pixel stage reads the list through a slot-select port. Both memory read ports are synchronous: data returns one clock after the address is presented.

Entry word layout:
- word 0 bits 9:0 hold the Y position with a bias of 64.
- word 1 bits 9:0 hold the X position.
- word 2 bits 10:1 hold the pattern number.
- word 3 holds the flags:
  - bits 3:0 palette
  - bit 8 selects 32-pixel width
  - bit 11 horizontal flip
  - bits 13:12 height code
  - bit 15 vertical flip

Top module: `spr_line_scan`

## Requirements
- R1: After reset, `list_count` is 0, and `scan_busy`, `scan_done`, `ovf_status` and `ovf_irq` are all 0.
- R2: A sprite hits line L when Y ≤ L < Y + H. Y is word0[9:0] minus 64, taken as a signed value. H is 16, 32, 64 or 64 lines for flag code 0, 1, 2 or 3. The row offset is L − Y. A slot's X is word1[9:0] and its palette is flags[3:0]; `list_flags` returns the whole word 3.
- R3: Entries are scanned from index 0 to 63, and hits fill slots 0 upward in that order. `list_zero` is 1 only for a slot taken from table entry 0.
- R4: The four plane words of a slot are read at addresses {pattern[9:0], plane[1:0], row[3:0]}, that is pattern*64 + plane*16 + (row mod 16). Plane p is returned in `list_planes[16p+15:16p]`. A 16-wide sprite keeps word2[1] as pattern bit 0.
- R5: When flag bit 15 is set, the row used for addressing is H − 1 − offset.
- R6: For H = 32, pattern bit 1 is cleared before the merge. For H = 64, pattern bits 2:1 are cleared before the merge. The merge ORs row bits 5:4 into pattern bits 2:1.
- R7: A sprite with flag bit 8 set fills two consecutive slots. The second slot has X + 16 (modulo 1024). Pattern bit 0 is 0 in the first slot and 1 in the second. With flag bit 11 set, these two values are swapped.
- R8: When a hit needs a 17th slot, the scan stops with `list_count` = 16. If `ovf_en` is 1, `ovf_status` goes high until the next `line_start` and `ovf_irq` pulses for one cycle. If `ovf_en` is 0, neither changes. Exactly 16 hits raise no overflow.
- R9: `scan_done` pulses for one cycle at the end of each scan. After that, `list_count` and the list stay unchanged until the next `line_start`, even if the table is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | Starts a scan; restarts a scan already running |
| line_num | input | 10 | Line to scan, latched when `line_start` is high |
| ovf_en | input | 1 | Enables overflow status and interrupt |
| sat_addr | output | 8 | Table word address {entry, word} |
| sat_data | input | 16 | Table read data, one cycle after the address |
| vram_addr | output | 16 | Plane word address |
| vram_data | input | 16 | Video memory read data, one cycle after the address |
| rd_slot | input | 4 | Slot selected for readout |
| list_x | output | 10 | X of the selected slot |
| list_pal | output | 4 | Palette of the selected slot |
| list_flags | output | 16 | Flag word of the selected slot |
| list_planes | output | 64 | Four plane words of the selected slot |
| list_zero | output | 1 | Selected slot came from table entry 0 |
| list_count | output | 5 | Number of filled slots |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle end-of-scan strobe |
| ovf_status | output | 1 | Overflow seen on this line |
| ovf_irq | output | 1 | One-cycle overflow interrupt |

## Verification
The main function is tried with four kinds of input:
- **Two narrow sprites on one line.** Shows that scan order maps to slot order and that the entry-0 marker lands on the right slot.
- **The same sprites at the first row, the last row and one row past the end.** Catches off-by-one errors in the hit window.
- **Vertically flipped and tall sprites (each height code).** Separates the row inversion from the pattern-bit merge.
- **Wide sprites with and without horizontal flip.** Shows the slot pairing, the +16 X offset and the swap of pattern bit 0.

Overflow is tried in three cases: 17 narrow hits, exactly 16 hits, and a wide sprite whose second half would be the 17th slot. The 17-hit case is run with the enable on and off. Together these show where the scan stops and when the flag and interrupt are gated.

// File: rtl/spr_line_scan.sv
module spr_line_scan #(
  parameter int NENT  = 64,
  parameter int NSLOT = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           line_start,
  input  logic [9:0]                     line_num,
  input  logic                           ovf_en,
  output logic [$clog2(NENT)+1:0]        sat_addr,
  input  logic [15:0]                    sat_data,
  output logic [15:0]                    vram_addr,
  input  logic [15:0]                    vram_data,
  input  logic [$clog2(NSLOT)-1:0]       rd_slot,
  output logic [9:0]                     list_x,
  output logic [3:0]                     list_pal,
  output logic [15:0]                    list_flags,
  output logic [63:0]                    list_planes,
  output logic                           list_zero,
  output logic [$clog2(NSLOT+1)-1:0]     list_count,
  output logic                           scan_busy,
  output logic                           scan_done,
  output logic                           ovf_status,
  output logic                           ovf_irq
);
  localparam int IW = $clog2(NENT);
  localparam int SW = $clog2(NSLOT);
  localparam int CW = $clog2(NSLOT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_EVAL, S_FETCH, S_DONE} st_t;
  st_t st;

  logic [IW-1:0] idx;
  logic [2:0]    cnt;
  logic          half;
  logic [9:0]    cur_line;
  logic [15:0]   w0, w1, w2, w3;

  logic [9:0]  lx    [NSLOT];
  logic [15:0] lfl   [NSLOT];
  logic [63:0] lpl   [NSLOT];
  logic        lz    [NSLOT];

  logic signed [11:0] ys, yend, ln, offs;
  logic [6:0]  hgt;
  logic [5:0]  voff;
  logic [9:0]  pn;
  logic        hit, last;
  logic [SW-1:0] slot;

  assign hgt  = (w3[13:12] == 2'd0) ? 7'd16 : (w3[13:12] == 2'd1) ? 7'd32 : 7'd64;
  assign ys   = $signed({2'b00, w0[9:0]}) - 12'sd64;
  assign yend = ys + $signed({5'b0, hgt});
  assign ln   = $signed({2'b00, cur_line});
  assign hit  = (ln >= ys) && (ln < yend);
  assign offs = ln - ys;
  assign voff = w3[15] ? (6'(hgt - 7'd1) - offs[5:0]) : offs[5:0];
  assign last = (idx == IW'(NENT - 1));
  assign slot = list_count[SW-1:0];

  always_comb begin
    pn = w2[10:1];
    if (w3[13:12] == 2'd1) pn[1] = 1'b0;
    else if (w3[13]) pn[2:1] = 2'b00;
    pn[2:1] = pn[2:1] | voff[5:4];
    if (w3[8]) pn[0] = half ^ w3[11];
  end

  assign sat_addr  = {idx, cnt[1:0]};
  assign vram_addr = {pn, cnt[1:0], voff[3:0]};
  assign scan_busy = (st != S_IDLE);
  assign scan_done = (st == S_DONE);

  assign list_x      = lx[rd_slot];
  assign list_flags  = lfl[rd_slot];
  assign list_pal    = lfl[rd_slot][3:0];
  assign list_planes = lpl[rd_slot];
  assign list_zero   = lz[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; half <= 1'b0; cur_line <= '0;
      w0 <= '0; w1 <= '0; w2 <= '0; w3 <= '0;
      list_count <= '0; ovf_status <= 1'b0; ovf_irq <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        lx[i] <= '0; lfl[i] <= '0; lpl[i] <= '0; lz[i] <= 1'b0;
      end
    end else begin
      ovf_irq <= 1'b0;
      if (line_start) begin
        st <= S_RD; idx <= '0; cnt <= '0; half <= 1'b0;
        list_count <= '0; ovf_status <= 1'b0; cur_line <= line_num;
      end else begin
        case (st)
          S_RD: begin
            cnt <= cnt + 3'd1;
            case (cnt)
              3'd1: w0 <= sat_data;
              3'd2: w1 <= sat_data;
              3'd3: w2 <= sat_data;
              3'd4: w3 <= sat_data;
              default: ;
            endcase
            if (cnt == 3'd4) begin
              st <= S_EVAL; cnt <= '0;
            end
          end
          S_EVAL: begin
            cnt <= '0;
            if (!hit) begin
              half <= 1'b0;
              if (last) st <= S_DONE;
              else begin idx <= idx + 1'b1; st <= S_RD; end
            end else if (list_count == CW'(NSLOT)) begin
              st <= S_DONE;
              if (ovf_en) begin ovf_status <= 1'b1; ovf_irq <= 1'b1; end
            end else begin
              st <= S_FETCH;
            end
          end
          S_FETCH: begin
            cnt <= cnt + 3'd1;
            case (cnt)
              3'd1: lpl[slot][15:0]  <= vram_data;
              3'd2: lpl[slot][31:16] <= vram_data;
              3'd3: lpl[slot][47:32] <= vram_data;
              3'd4: lpl[slot][63:48] <= vram_data;
              default: ;
            endcase
            if (cnt == 3'd4) begin
              cnt <= '0;
              lx[slot]  <= w1[9:0] + (half ? 10'd16 : 10'd0);
              lfl[slot] <= w3;
              lz[slot]  <= (idx == '0);
              list_count <= list_count + 1'b1;
              if (w3[8] && !half) begin
                half <= 1'b1; st <= S_EVAL;
              end else begin
                half <= 1'b0;
                if (last) st <= S_DONE;
                else begin idx <= idx + 1'b1; st <= S_RD; end
              end
            end
          end
          S_DONE: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    list_count <= CW'(NSLOT));

  a_r8_irq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (list_count == CW'(NSLOT)) && ovf_status && scan_done);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  a_r9_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_busy && !line_start) |=> $stable(list_count));

  a_r7_one_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy && !line_start) |=>
      (list_count == $past(list_count)) || (list_count == $past(list_count) + 1'b1));
endmodule

// File: tb/tb_spr_line_scan.sv
`timescale 1ns/1ps
module tb_spr_line_scan;
  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, ovf_en = 1'b0;
  logic [9:0] line_num = '0;
  logic [7:0] sat_addr;
  logic [15:0] sat_data, vram_addr, vram_data;
  logic [3:0] rd_slot = '0;
  logic [9:0] list_x;
  logic [3:0] list_pal;
  logic [15:0] list_flags;
  logic [63:0] list_planes;
  logic list_zero, scan_busy, scan_done, ovf_status, ovf_irq;
  logic [4:0] list_count;

  logic [15:0] sat_mem [256];
  int checks = 0, fails = 0, irqs = 0, cycles = 0;

  always #5 clk = ~clk;

  spr_line_scan dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .ovf_en(ovf_en), .sat_addr(sat_addr), .sat_data(sat_data),
    .vram_addr(vram_addr), .vram_data(vram_data), .rd_slot(rd_slot),
    .list_x(list_x), .list_pal(list_pal), .list_flags(list_flags),
    .list_planes(list_planes), .list_zero(list_zero), .list_count(list_count),
    .scan_busy(scan_busy), .scan_done(scan_done), .ovf_status(ovf_status),
    .ovf_irq(ovf_irq));

  function automatic logic [15:0] vf(input logic [15:0] a);
    return a ^ 16'h5A3C ^ {a[7:0], a[15:8]};
  endfunction

  always_ff @(posedge clk) begin
    sat_data  <= sat_mem[sat_addr];
    vram_data <= vf(vram_addr);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_sat();
    for (int i = 0; i < 256; i++) sat_mem[i] = 16'h0;
  endtask

  task automatic put(input int i, input logic [9:0] yraw, input logic [9:0] x,
                     input logic [9:0] pat, input logic [15:0] fl);
    sat_mem[i*4+0] = {6'd0, yraw};
    sat_mem[i*4+1] = {6'd0, x};
    sat_mem[i*4+2] = {5'd0, pat, 1'b0};
    sat_mem[i*4+3] = fl;
  endtask

  task automatic run_line(input logic [9:0] ln);
    int n = 0;
    irqs = 0;
    @(negedge clk); line_num = ln; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    while (!scan_done && n < 5000) begin
      if (ovf_irq) irqs++;
      @(negedge clk); n++;
    end
    if (ovf_irq) irqs++;
  endtask

  task automatic chk_slot(input string req, input int s, input logic [9:0] x,
                          input logic [15:0] fl, input logic [9:0] pn,
                          input logic [3:0] row, input logic z);
    rd_slot = 4'(s); #1;
    chk({req, " x"}, 64'(list_x), 64'(x));
    chk({req, " pal"}, 64'(list_pal), 64'(fl[3:0]));
    chk({req, " flags"}, 64'(list_flags), 64'(fl));
    chk({req, " zero"}, 64'(list_zero), 64'(z));
    chk({req, " planes"}, list_planes,
        {vf({pn, 2'd3, row}), vf({pn, 2'd2, row}), vf({pn, 2'd1, row}), vf({pn, 2'd0, row})});
  endtask

  task automatic t_reset();
    chk("R1 count", 64'(list_count), 0);
    chk("R1 busy", 64'(scan_busy), 0);
    chk("R1 done", 64'(scan_done), 0);
    chk("R1 ovf", 64'(ovf_status), 0);
    chk("R1 irq", 64'(ovf_irq), 0);
  endtask

  task automatic t_basic();
    clear_sat();
    put(0, 10'h4C, 10'd7, 10'h12, 16'h000A);
    put(5, 10'h4A, 10'd100, 10'h55, 16'h0003);
    run_line(10'd12);
    chk("R3 count", 64'(list_count), 2);
    chk_slot("R3 R4 slot0", 0, 10'd7, 16'h000A, 10'h12, 4'd0, 1'b1);
    chk_slot("R2 R4 slot1", 1, 10'd100, 16'h0003, 10'h55, 4'd2, 1'b0);
    run_line(10'd25);
    chk("R2 last row count", 64'(list_count), 2);
    chk_slot("R2 last row", 1, 10'd100, 16'h0003, 10'h55, 4'd15, 1'b0);
    run_line(10'd26);
    chk("R2 past end count", 64'(list_count), 1);
    chk_slot("R2 past end slot0", 0, 10'd7, 16'h000A, 10'h12, 4'd14, 1'b1);
    run_line(10'd9);
    chk("R2 before start count", 64'(list_count), 0);
  endtask

  task automatic t_vflip();
    clear_sat();
    put(3, 10'h4A, 10'd40, 10'h20, 16'h8001);
    run_line(10'd12);
    chk("R5 count", 64'(list_count), 1);
    chk_slot("R5 vflip", 0, 10'd40, 16'h8001, 10'h20, 4'd13, 1'b0);
  endtask

  task automatic t_tall();
    clear_sat();
    put(2, 10'h40, 10'd5, 10'h5F, 16'h2000);
    put(7, 10'h40 + 10'd100, 10'd9, 10'h40, 16'h9000);
    run_line(10'd37);
    chk("R6 h64 count", 64'(list_count), 1);
    chk_slot("R6 h64", 0, 10'd5, 16'h2000, 10'h5D, 4'd5, 1'b0);
    run_line(10'd103);
    chk("R6 h32 count", 64'(list_count), 1);
    chk_slot("R6 R5 h32 vflip", 0, 10'd9, 16'h9000, 10'h42, 4'd12, 1'b0);
    run_line(10'd63);
    chk("R2 h64 last row", 64'(list_count), 1);
    run_line(10'd64);
    chk("R2 h64 past end", 64'(list_count), 0);
    put(2, 10'h40, 10'd5, 10'h5F, 16'h3000);
    run_line(10'd37);
    chk_slot("R6 code3", 0, 10'd5, 16'h3000, 10'h5D, 4'd5, 1'b0);
  endtask

  task automatic t_wide();
    clear_sat();
    put(4, 10'h40 + 10'd50, 10'd200, 10'h31, 16'h0100);
    run_line(10'd50);
    chk("R7 count", 64'(list_count), 2);
    chk_slot("R7 first", 0, 10'd200, 16'h0100, 10'h30, 4'd0, 1'b0);
    chk_slot("R7 second", 1, 10'd216, 16'h0100, 10'h31, 4'd0, 1'b0);
    put(4, 10'h40 + 10'd50, 10'd200, 10'h31, 16'h0900);
    run_line(10'd50);
    chk_slot("R7 hflip first", 0, 10'd200, 16'h0900, 10'h31, 4'd0, 1'b0);
    chk_slot("R7 hflip second", 1, 10'd216, 16'h0900, 10'h30, 4'd0, 1'b0);
  endtask

  task automatic t_overflow();
    clear_sat();
    for (int i = 0; i < 17; i++) put(i, 10'h40 + 10'd200, 10'(i), 10'(i), 16'h0000);
    ovf_en = 1'b1;
    run_line(10'd200);
    chk("R8 count", 64'(list_count), 16);
    chk("R8 status", 64'(ovf_status), 1);
    chk("R8 irq pulses", 64'(irqs), 1);
    chk_slot("R8 R3 slot15", 15, 10'd15, 16'h0, 10'd15, 4'd0, 1'b0);
    chk_slot("R3 slot0 zero", 0, 10'd0, 16'h0, 10'd0, 4'd0, 1'b1);
    ovf_en = 1'b0;
    run_line(10'd200);
    chk("R8 disabled count", 64'(list_count), 16);
    chk("R8 disabled status", 64'(ovf_status), 0);
    chk("R8 disabled irq", 64'(irqs), 0);
    put(16, 10'h0, 10'd0, 10'd0, 16'h0);
    ovf_en = 1'b1;
    run_line(10'd200);
    chk("R8 exact16 count", 64'(list_count), 16);
    chk("R8 exact16 status", 64'(ovf_status), 0);
    put(15, 10'h0, 10'd0, 10'd0, 16'h0);
    put(20, 10'h40 + 10'd200, 10'd300, 10'h33, 16'h0100);
    run_line(10'd200);
    chk("R8 wide split count", 64'(list_count), 16);
    chk("R8 wide split status", 64'(ovf_status), 1);
    chk_slot("R8 R7 wide split slot15", 15, 10'd300, 16'h0100, 10'h32, 4'd0, 1'b0);
  endtask

  task automatic t_hold();
    clear_sat();
    put(1, 10'h40, 10'd1, 10'd1, 16'h0);
    run_line(10'd0);
    clear_sat();
    repeat (20) @(negedge clk);
    chk("R9 count held", 64'(list_count), 1);
    chk("R9 done low", 64'(scan_done), 0);
    chk_slot("R9 list held", 0, 10'd1, 16'h0, 10'd1, 4'd0, 1'b0);
  endtask

  initial begin
    clear_sat();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_vflip();
    t_tall();
    t_wide();
    t_overflow();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule